// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

This block raises a message X to an exponent e modulo an odd modulus N, working entirely in the Montgomery domain with R = 2^W. It drives two bit-serial Montgomery multipliers. The main multiplier runs the square-and-multiply loop. The auxiliary multiplier converts the message into Montgomery form during the first squaring and, at the end, multiplies the accumulator by the constant 1 to bring it back to plain form. The accumulator starts at R mod N. The converted message stays in a holding register, and the main multiplier takes it only for exponent bits that are set.

The exponent is scanned from its most significant set bit down to bit 0. Every scanned bit costs one squaring. Every set bit costs one more multiplication by the converted message. Leading zero bits of the exponent cost nothing. A zero exponent skips the loop and runs only the final conversion. Each multiplier keeps its running sum in carry-save form. It resolves that sum to binary once, when the result is handed on, with one conditional subtraction of N. Every operand therefore stays binary and below N. The caller supplies R mod N and R² mod N. A single-cycle start pulse launches a run. A single-cycle done pulse marks the result.

Top module: `modexp_seq`

## Requirements
- R1: For odd N with 1 < N < 2^W, X < N, r_mod = 2^W mod N and r2_mod = 2^(2W) mod N, the result presented with done equals X^e mod N.
- R2: With e = 0 the result is 1 (for N > 1), produced by the final conversion alone.
- R3: done rises exactly K·(W+3) clock edges after the edge that samples start. K = 1 for e = 0; otherwise K = (t+1) + HW(e) + 1, where t is the bit index of the highest set bit of e and HW(e) is the number of set bits.
- R4: done is high for exactly one cycle per run, and result changes only in the cycle in which done is high.
- R5: A start pulse that arrives while a run is in progress is ignored: the run's result and timing are unchanged.
- R6: After reset, done is 0 and result is 0.
- R7: Whenever done is high, result is strictly less than the modulus of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that samples the operands while idle |
| msg | input | W | Message X, below the modulus |
| expo | input | EW | Exponent e |
| modulus | input | W | Odd modulus N |
| r_mod | input | W | 2^W mod N |
| r2_mod | input | W | 2^(2W) mod N |
| result | output | W | X^e mod N, valid while done is high and held until the next run ends |
| done | output | 1 | One-cycle pulse marking a finished run |

## Verification
Errors in the bit index, the operation order or the carry-save state all show up as a wrong result when done pulses. Exponents with few or many set bits, and with the top bit near either end of the word, make a wrong branch at any bit visible. A fault in the sequencing state, such as a skipped or extra operation, also moves done by a whole multiple of W+3 cycles, so the exact-cycle latency check catches it within the same run. A spurious start that the design accepted mid-run would change both the timing and the value of the first result after it.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SQR  = 2'd1,
    ST_MUL  = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/msb_locate.sv
module msb_locate #(
  parameter int EW = 16,
  localparam int IW = (EW > 1) ? $clog2(EW) : 1
) (
  input  logic [EW-1:0] vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < EW; i++) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic [W-1:0] res,
  output logic         rdy
);
  localparam int CW  = W + 2;
  localparam int CNW = $clog2(W + 1);

  logic [W-1:0]   a_sh, b_q, m_q;
  logic [W:0]     bm_q;
  logic [CW-1:0]  s_q, c_q;
  logic [CNW-1:0] cnt_q;
  logic           run_q;

  logic           xk, qb;
  logic [CW-1:0]  addend, s3, mj, tot, red;

  always_comb begin
    xk = a_sh[0];
    qb = s_q[0] ^ c_q[0] ^ (xk & b_q[0]);
    unique case ({xk, qb})
      2'b00:   addend = '0;
      2'b01:   addend = CW'(m_q);
      2'b10:   addend = CW'(b_q);
      default: addend = CW'(bm_q);
    endcase
    s3  = s_q ^ c_q ^ addend;
    mj  = (s_q & c_q) | (s_q & addend) | (c_q & addend);
    tot = s_q + c_q;
    red = (tot >= CW'(m_q)) ? (tot - CW'(m_q)) : tot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      rdy   <= 1'b0;
      res   <= '0;
      cnt_q <= '0;
      a_sh  <= '0;
      b_q   <= '0;
      m_q   <= '0;
      bm_q  <= '0;
      s_q   <= '0;
      c_q   <= '0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        a_sh  <= a;
        b_q   <= b;
        m_q   <= m;
        bm_q  <= {1'b0, b} + {1'b0, m};
        s_q   <= '0;
        c_q   <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == CNW'(W)) begin
          res   <= red[W-1:0];
          rdy   <= 1'b1;
          run_q <= 1'b0;
        end else begin
          s_q   <= {1'b0, s3[CW-1:1]};
          c_q   <= mj;
          a_sh  <= {1'b0, a_sh[W-1:1]};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/modexp_seq.sv
module modexp_seq
  import modexp_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  msg,
  input  logic [EW-1:0] expo,
  input  logic [W-1:0]  modulus,
  input  logic [W-1:0]  r_mod,
  input  logic [W-1:0]  r2_mod,
  output logic [W-1:0]  result,
  output logic          done
);
  localparam int IW = (EW > 1) ? $clog2(EW) : 1;
  localparam logic [W-1:0] ONE = W'(1);

  seq_state_e    st_q;
  logic [EW-1:0] exp_q;
  logic [IW-1:0] bit_q;
  logic [W-1:0]  mod_q, xm_q;
  logic          go_a, go_b;
  logic [W-1:0]  opa_a, opb_a, opa_b, opb_b;
  logic [W-1:0]  res_a, res_b;
  logic          rdy_a, rdy_b;
  logic [IW-1:0] top_idx;
  logic          exp_nz;
  logic [W-1:0]  xm_now;
  logic          in_idle;

  msb_locate #(.EW(EW)) u_msb (.vec(expo), .idx(top_idx), .any(exp_nz));

  mont_mul #(.W(W)) u_main (
    .clk(clk), .rst(rst), .go(go_a), .a(opa_a), .b(opb_a), .m(mod_q),
    .res(res_a), .rdy(rdy_a));

  mont_mul #(.W(W)) u_aux (
    .clk(clk), .rst(rst), .go(go_b), .a(opa_b), .b(opb_b), .m(mod_q),
    .res(res_b), .rdy(rdy_b));

  assign xm_now  = rdy_b ? res_b : xm_q;
  assign in_idle = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      exp_q  <= '0;
      bit_q  <= '0;
      mod_q  <= '0;
      xm_q   <= '0;
      go_a   <= 1'b0;
      go_b   <= 1'b0;
      opa_a  <= '0;
      opb_a  <= '0;
      opa_b  <= '0;
      opb_b  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      go_a <= 1'b0;
      go_b <= 1'b0;
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            exp_q <= expo;
            mod_q <= modulus;
            bit_q <= top_idx;
            go_b  <= 1'b1;
            if (exp_nz) begin
              st_q  <= ST_SQR;
              go_a  <= 1'b1;
              opa_a <= r_mod;
              opb_a <= r_mod;
              opa_b <= msg;
              opb_b <= r2_mod;
            end else begin
              st_q  <= ST_FIN;
              opa_b <= r_mod;
              opb_b <= ONE;
            end
          end
        end
        ST_SQR: begin
          if (rdy_b) xm_q <= res_b;
          if (rdy_a) begin
            if (exp_q[bit_q]) begin
              st_q  <= ST_MUL;
              go_a  <= 1'b1;
              opa_a <= res_a;
              opb_a <= xm_now;
            end else if (bit_q == '0) begin
              st_q  <= ST_FIN;
              go_b  <= 1'b1;
              opa_b <= res_a;
              opb_b <= ONE;
            end else begin
              bit_q <= bit_q - 1'b1;
              go_a  <= 1'b1;
              opa_a <= res_a;
              opb_a <= res_a;
            end
          end
        end
        ST_MUL: begin
          if (rdy_a) begin
            if (bit_q == '0) begin
              st_q  <= ST_FIN;
              go_b  <= 1'b1;
              opa_b <= res_a;
              opb_b <= ONE;
            end else begin
              st_q  <= ST_SQR;
              bit_q <= bit_q - 1'b1;
              go_a  <= 1'b1;
              opa_a <= res_a;
              opb_a <= res_a;
            end
          end
        end
        default: begin
          if (rdy_b) begin
            result <= res_b;
            done   <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module modexp_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] mod_q,
  input logic         in_idle,
  input logic         go_a,
  input logic         go_b
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_held_R4: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  assert_result_reduced_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < mod_q));

  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_idle && start) |=> $stable(mod_q));

  assert_no_op_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> !(go_a || go_b));
endmodule

bind modexp_seq modexp_checker #(.W(W)) u_modexp_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .result(result),
  .mod_q(mod_q), .in_idle(in_idle), .go_a(go_a), .go_b(go_b));

// File: tb/tb_modexp_seq.sv
`timescale 1ns/1ps
module tb_modexp_seq;
  localparam int W  = 16;
  localparam int EW = 16;
  localparam int P  = W + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  msg = '0, modulus = '0, r_mod = '0, r2_mod = '0;
  logic [EW-1:0] expo = '0;
  logic [W-1:0]  result;
  logic          done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  modexp_seq #(.W(W), .EW(EW)) dut (
    .clk(clk), .rst(rst), .start(start), .msg(msg), .expo(expo),
    .modulus(modulus), .r_mod(r_mod), .r2_mod(r2_mod),
    .result(result), .done(done));

  function automatic longint ref_pow(longint x, longint e, longint n);
    longint acc = 1 % n;
    longint b = x % n;
    for (int i = EW - 1; i >= 0; i--) begin
      acc = (acc * acc) % n;
      if (e[i]) acc = (acc * b) % n;
    end
    return acc;
  endfunction

  function automatic int ref_ops(logic [EW-1:0] e);
    int t = 0;
    if (e == '0) return 1;
    for (int i = 0; i < EW; i++) if (e[i]) t = i;
    return t + 1 + $countones(e) + 1;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 done after reset", done, 0);
    check("R6 result after reset", result, 0);
  endtask

  // One run: checks value (R1/R2), latency (R3), pulse and hold (R4),
  // and optionally a spurious start mid-run (R5).
  task automatic run_case(string req, logic [W-1:0] x, logic [EW-1:0] e,
                          logic [W-1:0] n, bit inject);
    longint nn = n;
    int cyc = 0;
    longint exp_val = ref_pow(x, e, nn);
    int exp_cyc = ref_ops(e) * P;
    logic [W-1:0] got;
    @(negedge clk);
    msg = x; expo = e; modulus = n;
    r_mod  = W'((64'd1 << W) % nn);
    r2_mod = W'((64'd1 << (2 * W)) % nn);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (inject && cyc == 40) begin
        start = 1'b1;
        msg = x ^ W'(5); expo = ~e; modulus = W'(65521);
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    got = result;
    check({req, " result"}, got, exp_val);
    check({req, " R3 latency"}, cyc, exp_cyc);
    @(negedge clk);
    check({req, " R4 done one cycle"}, done, 0);
    repeat (3) @(negedge clk);
    check({req, " R4 result held"}, result, got);
  endtask

  initial begin
    do_reset();
    run_case("R1 small e=3",        16'd1234,  16'd3,      16'd65521, 1'b0);
    run_case("R1 e=2^15+1",         16'd4321,  16'h8001,   16'd65521, 1'b0);
    run_case("R1 all ones e",       16'd777,   16'hFFFF,   16'd40961, 1'b0);
    run_case("R1 e=1 leading zeros",16'd999,   16'd1,      16'd1001,  1'b0);
    run_case("R1 N near R",         16'd65534, 16'hA5A5,   16'd65535, 1'b0);
    run_case("R1 X=0",              16'd0,     16'd19,     16'd12345, 1'b0);
    run_case("R1 N=3",              16'd2,     16'd6,      16'd3,     1'b0);
    run_case("R1 X=N-1 odd e",      16'd30000, 16'd7,      16'd30001, 1'b0);
    run_case("R2 zero exponent",    16'd555,   16'd0,      16'd65521, 1'b0);
    run_case("R2 zero exp small N", 16'd2,     16'd0,      16'd5,     1'b0);
    run_case("R5 start while busy", 16'd2468,  16'h0F0F,   16'd50021, 1'b1);
    run_case("R7 sparse e",         16'd100,   16'h4000,   16'd257,   1'b0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule